// File: doc/BRIEF.md
# Peripheral Clock Gating and Brown-Out Sleep Controller

This block sits beside a small processor core and decides which of four peripherals receive a clock. A byte-wide register port exposes a gating register, in which a one in a peripheral's bit stops that peripheral's clock and a zero restores it. A second register, on the same port, lets software ask for the brown-out detector to be switched off during the next sleep. The request is guarded by a two-write unlock sequence. It takes hold only after a short delay, and it lapses by itself shortly afterwards.

When the core executes a sleep, it pulses a strobe into the block. If the brown-out sleep disable is live in that cycle, the block raises a brown-out-off request. It holds that request until a wake-up strobe arrives. A further guard refuses to stop the converter's clock while the converter is still enabled, and reports the refused write on an error output.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After reset every clock enable is high, the brown-out-off request and the brown-out sleep status are low, the error output is low, and both registers read as zero.
- R2: A write to address 0 stores data bits 3..0 in the gating register. Bit 0 is the converter, bit 1 the serial port, bit 2 the synchronous serial link and bit 3 timer 1. In the cycle after the write, clk_en[i] equals the inverse of the stored bit i.
- R3: Bits 7..4 of address 0 always read as zero, and the values written to them have no effect.
- R4: At address 1, write bit 1 is the arm bit and write bit 0 is the key bit. On readback, bit 1 shows the sleep disable as live, bit 0 shows the unlock window as open, and bits 7..2 read zero. A write with the arm bit one and the key bit zero, made while the window is closed, has no effect.
- R5: A write to address 1 with both the arm bit and the key bit at one opens the unlock window for the next 4 clock edges. An arm-only write sampled on one of those edges is accepted and closes the window. An arm-only write sampled later is ignored.
- R6: The sleep disable becomes live on the third clock edge after an accepted arm write. It stays live for exactly 3 cycles and then clears itself.
- R7: A sleep strobe sampled while the sleep disable is live sets bod_off on the next edge, and bod_off then holds until a wake-up. A sleep strobe at any other time leaves bod_off low.
- R8: A wake-up strobe clears bod_off on the next edge, and it takes priority over a sleep strobe in the same cycle.
- R9: A write to address 0 with bit 0 at one while adc_enable is high leaves the converter's gating bit unchanged, still stores bits 3..1, and raises adc_gate_err for exactly the next cycle.
- R10: An arm-only write while a sleep disable is already pending or live is ignored and does not restart the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 gating, 1 brown-out control |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| sleep_req | input | 1 | One-cycle sleep entry strobe |
| wake_req | input | 1 | One-cycle wake-up strobe |
| adc_enable | input | 1 | High while the converter is still enabled |
| clk_en | output | 4 | Per-peripheral clock enables, bit order as in R2 |
| bod_off | output | 1 | Request to switch off the brown-out detector |
| bods_status | output | 1 | Sleep disable is live |
| adc_gate_err | output | 1 | Pulse for a refused converter gating write |

## Verification
The bench places the arm write on the last edge of the unlock window and on the first edge after it. A design with an off-by-one window would accept both writes or refuse both. It counts the cycle the sleep disable rises and the cycle it falls, which catches a delay or a live period of the wrong length. It gives a sleep strobe just outside the live period, and a sleep and wake-up in the same cycle, which exposes a latched request or the wrong priority. It also re-arms while a disable is pending and writes the converter bit while the converter is enabled. A design that restarted its timing, or stopped the converter's clock anyway, shows a difference from the cycle model within a few edges.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;
   typedef enum logic {
      SEL_GATE = 1'b0,
      SEL_BOD  = 1'b1
   } reg_sel_e;

   localparam int IDX_ADC    = 0;
   localparam int IDX_USART  = 1;
   localparam int IDX_SPI    = 2;
   localparam int IDX_TIMER1 = 3;

   localparam int BOD_KEY_BIT = 0;
   localparam int BOD_ARM_BIT = 1;
endpackage

// File: rtl/gate_reg.sv
module gate_reg #(
   parameter int NUM_CH    = 4,
   parameter int GUARD_IDX = 0,
   parameter bit GUARD_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [NUM_CH-1:0] wr_bits,
   input  logic              guard_busy,
   output logic [NUM_CH-1:0] gate_q,
   output logic              guard_err
);
   if (NUM_CH < 1) begin : g_chk_ch
      $error("gate_reg: NUM_CH must be at least 1");
   end
   if (GUARD_IDX < 0 || GUARD_IDX >= NUM_CH) begin : g_chk_idx
      $error("gate_reg: GUARD_IDX out of range");
   end

   logic [NUM_CH-1:0] gate_d;
   logic              refuse;

   if (GUARD_EN) begin : g_guard
      assign refuse = wr_stb && wr_bits[GUARD_IDX] && guard_busy;
   end else begin : g_noguard
      assign refuse = 1'b0;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
      if (GUARD_EN && i == GUARD_IDX) begin : g_guarded
         assign gate_d[i] = !wr_stb ? gate_q[i] :
                            (refuse ? gate_q[i] : wr_bits[i]);
      end else begin : g_plain
         assign gate_d[i] = wr_stb ? wr_bits[i] : gate_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q    <= '0;
         guard_err <= 1'b0;
      end else begin
         gate_q    <= gate_d;
         guard_err <= refuse;
      end
   end

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !(wr_bits[GUARD_IDX] && guard_busy)) |=> (gate_q == $past(wr_bits)));

   assert_guard_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (GUARD_EN && wr_stb && wr_bits[GUARD_IDX] && guard_busy)
         |=> (gate_q[GUARD_IDX] == $past(gate_q[GUARD_IDX])) && guard_err);

   assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(gate_q));
endmodule

// File: rtl/bods_seq.sv
module bods_seq #(
   parameter int WIN = 4,
   parameter int DLY = 3,
   parameter int LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_wr,
   input  logic arm_wr,
   output logic win_open,
   output logic bods_active
);
   if (WIN < 1) begin : g_chk_win
      $error("bods_seq: WIN must be at least 1");
   end
   if (DLY < 1) begin : g_chk_dly
      $error("bods_seq: DLY must be at least 1");
   end
   if (LEN < 1) begin : g_chk_len
      $error("bods_seq: LEN must be at least 1");
   end

   localparam int WW = $clog2(WIN + 1);
   localparam int DW = $clog2(DLY + 1);
   localparam int LW = $clog2(LEN + 1);
   localparam logic [WW-1:0] WIN_V = WW'(WIN);
   localparam logic [DW-1:0] DLY_V = DW'(DLY);
   localparam logic [LW-1:0] LEN_V = LW'(LEN);

   logic [WW-1:0] win_q;
   logic [DW-1:0] pend_q;
   logic [LW-1:0] act_q;
   logic          active_q;
   logic          arm_ok;

   assign arm_ok = arm_wr && (win_q != '0) && (pend_q == '0) && !active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (arm_ok) begin
         win_q <= '0;
      end else if (key_wr) begin
         win_q <= WIN_V;
      end else if (win_q != '0) begin
         win_q <= win_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (arm_ok) begin
         pend_q <= DLY_V;
      end else if (pend_q != '0) begin
         pend_q <= pend_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         act_q    <= '0;
      end else if (pend_q == DW'(1)) begin
         active_q <= 1'b1;
         act_q    <= LEN_V;
      end else if (active_q) begin
         act_q <= act_q - 1'b1;
         if (act_q == LW'(1)) active_q <= 1'b0;
      end
   end

   assign win_open    = (win_q != '0);
   assign bods_active = active_q;

   assert_win_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      win_q <= WIN_V);

   assert_late_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_wr && !win_open && pend_q == '0 && !active_q) |=> (pend_q == '0));

   assert_rise_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> ($past(pend_q) == DW'(1)));

   assert_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_q) |-> ($past(act_q) == LW'(1)));

   assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(active_q && pend_q != '0));
endmodule

// File: rtl/bod_sleep_ctl.sv
module bod_sleep_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic wake_req,
   input  logic bods_active,
   output logic bod_off
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bod_off <= 1'b0;
      end else if (wake_req) begin
         bod_off <= 1'b0;
      end else if (sleep_req && bods_active) begin
         bod_off <= 1'b1;
      end
   end

   assert_sleep_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bod_off) |-> $past(sleep_req && bods_active));

   assert_wake_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !bod_off);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bod_off && !wake_req) |=> bod_off);
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl #(
   parameter int DATA_W     = 8,
   parameter int NUM_PERIPH = 4,
   parameter int UNLOCK_WIN = 4,
   parameter int ARM_DELAY  = 3,
   parameter int ACTIVE_LEN = 3,
   parameter bit ADC_GUARD  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_addr,
   input  logic                  bus_wr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic                  sleep_req,
   input  logic                  wake_req,
   input  logic                  adc_enable,
   output logic [NUM_PERIPH-1:0] clk_en,
   output logic                  bod_off,
   output logic                  bods_status,
   output logic                  adc_gate_err
);
   import pwr_gate_pkg::*;

   if (NUM_PERIPH >= DATA_W) begin : g_chk_width
      $error("pwr_gate_ctrl: NUM_PERIPH must leave reserved bits");
   end
   if (DATA_W < 2) begin : g_chk_data
      $error("pwr_gate_ctrl: DATA_W too small for control bits");
   end

   localparam int RSV_W = DATA_W - NUM_PERIPH;

   reg_sel_e              sel;
   logic                  wr_gate;
   logic                  wr_bod;
   logic                  key_wr;
   logic                  arm_wr;
   logic [NUM_PERIPH-1:0] gate_q;
   logic                  win_open;
   logic                  bods_active;
   logic                  unused_hi;

   assign sel     = reg_sel_e'(bus_addr);
   assign wr_gate = bus_wr && (sel == SEL_GATE);
   assign wr_bod  = bus_wr && (sel == SEL_BOD);
   assign key_wr  = wr_bod && bus_wdata[BOD_ARM_BIT] && bus_wdata[BOD_KEY_BIT];
   assign arm_wr  = wr_bod && bus_wdata[BOD_ARM_BIT] && !bus_wdata[BOD_KEY_BIT];
   assign unused_hi = ^bus_wdata[DATA_W-1:NUM_PERIPH];

   gate_reg #(
      .NUM_CH    (NUM_PERIPH),
      .GUARD_IDX (IDX_ADC),
      .GUARD_EN  (ADC_GUARD)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (wr_gate),
      .wr_bits    (bus_wdata[NUM_PERIPH-1:0]),
      .guard_busy (adc_enable),
      .gate_q     (gate_q),
      .guard_err  (adc_gate_err)
   );

   bods_seq #(
      .WIN (UNLOCK_WIN),
      .DLY (ARM_DELAY),
      .LEN (ACTIVE_LEN)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .key_wr      (key_wr),
      .arm_wr      (arm_wr),
      .win_open    (win_open),
      .bods_active (bods_active)
   );

   bod_sleep_ctl u_sleep (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_req),
      .wake_req    (wake_req),
      .bods_active (bods_active),
      .bod_off     (bod_off)
   );

   assign clk_en      = ~gate_q;
   assign bods_status = bods_active;

   always_comb begin
      bus_rdata = '0;
      if (sel == SEL_GATE) begin
         bus_rdata = {{RSV_W{1'b0}}, gate_q};
      end else begin
         bus_rdata[BOD_ARM_BIT] = bods_active;
         bus_rdata[BOD_KEY_BIT] = win_open;
      end
   end

   assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_GATE) |-> (bus_rdata[DATA_W-1:NUM_PERIPH] == '0));

   assert_bod_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bod_off |-> (clk_en == $past(clk_en) || $past(wr_gate)));
endmodule

// File: tb/sim_pwr_gate_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_gate_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       sleep_req = 1'b0;
   logic       wake_req = 1'b0;
   logic       adc_enable = 1'b0;
   logic [3:0] clk_en;
   logic       bod_off;
   logic       bods_status;
   logic       adc_gate_err;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwr_gate_ctrl u0 (
      .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .sleep_req (sleep_req),
      .wake_req (wake_req), .adc_enable (adc_enable), .clk_en (clk_en),
      .bod_off (bod_off), .bods_status (bods_status), .adc_gate_err (adc_gate_err)
   );

   // behavioural reference state
   int m_gate = 0, m_win = 0, m_pend = 0, m_cnt = 0;
   int m_act = 0, m_off = 0, m_err = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_gate = 0; m_win = 0; m_pend = 0; m_cnt = 0;
         m_act = 0; m_off = 0; m_err = 0;
      end else begin : step
         int v, n_win, n_pend, n_cnt, n_act, n_off, n_err;
         bit arm_ok;
         n_err = 0;
         if (bus_wr && bus_addr == 1'b0) begin
            v = bus_wdata & 8'h0F;
            if ((v & 1) != 0 && adc_enable) begin
               v = (v & 14) | (m_gate & 1);
               n_err = 1;
            end
            m_gate = v;
         end
         arm_ok = bus_wr && bus_addr && bus_wdata[1:0] == 2'b10 &&
                  m_win > 0 && m_pend == 0 && m_act == 0;
         n_win = (m_win > 0) ? m_win - 1 : 0;
         if (bus_wr && bus_addr && bus_wdata[1:0] == 2'b11) n_win = 4;
         if (arm_ok) n_win = 0;
         n_pend = (m_pend > 0) ? m_pend - 1 : 0;
         if (arm_ok) n_pend = 3;
         n_act = m_act; n_cnt = m_cnt;
         if (m_pend == 1) begin
            n_act = 1; n_cnt = 3;
         end else if (m_act != 0) begin
            n_cnt = m_cnt - 1;
            if (m_cnt == 1) n_act = 0;
         end
         n_off = m_off;
         if (wake_req) n_off = 0;
         else if (sleep_req && m_act != 0) n_off = 1;
         m_win = n_win; m_pend = n_pend; m_act = n_act; m_cnt = n_cnt;
         m_off = n_off; m_err = n_err;
      end
   end

   task automatic chk(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   // compare on every falling edge, before inputs move
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 clk_en", int'(clk_en), (~m_gate) & 15);
         if (bus_addr == 1'b0) chk("R3 rdata gate", int'(bus_rdata), m_gate);
         else chk("R4 rdata bod", int'(bus_rdata), (m_act << 1) | (m_win > 0 ? 1 : 0));
         chk("R7 R8 bod_off", int'(bod_off), m_off);
         chk("R6 bods_status", int'(bods_status), m_act);
         chk("R9 adc_gate_err", int'(adc_gate_err), m_err);
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(bit a, logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick(1);
      bus_wr = 1'b0; bus_wdata = 8'h00;
   endtask

   task automatic pulse_sleep(bit s, bit w);
      sleep_req = s; wake_req = w;
      tick(1);
      sleep_req = 1'b0; wake_req = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 clk_en", int'(clk_en), 15);
      chk("R1 bod_off", int'(bod_off), 0);
      chk("R1 status", int'(bods_status), 0);
      chk("R1 err", int'(adc_gate_err), 0);
      chk("R1 rdata", int'(bus_rdata), 0);

      // R2 R3 gating writes
      wr(1'b0, 8'h0F); chk("R2 all gated", int'(clk_en), 0);
      wr(1'b0, 8'hF5); chk("R3 reserved", int'(bus_rdata), 8'h05);
      wr(1'b0, 8'h0A); chk("R2 pattern", int'(clk_en), 5);
      wr(1'b0, 8'h00); chk("R2 restore", int'(clk_en), 15);

      // R9 converter guard
      adc_enable = 1'b1;
      wr(1'b0, 8'h0F);
      chk("R9 adc kept", int'(clk_en), 1);
      chk("R9 err pulse", int'(adc_gate_err), 1);
      tick(1); chk("R9 err one cycle", int'(adc_gate_err), 0);
      adc_enable = 1'b0; wr(1'b0, 8'h01);
      adc_enable = 1'b1; wr(1'b0, 8'h00);
      chk("R9 clear allowed", int'(clk_en), 15);
      adc_enable = 1'b0;

      // R4 arm without unlock
      wr(1'b1, 8'h02); tick(4);
      chk("R4 no unlock", int'(bods_status), 0);

      // R5 R6 R7 R8 arm, sleep, wake
      wr(1'b1, 8'h03); tick(1);
      wr(1'b1, 8'h02);
      tick(2); chk("R6 not yet", int'(bods_status), 0);
      tick(1); chk("R6 live", int'(bods_status), 1);
      pulse_sleep(1'b1, 1'b0); chk("R7 bod_off set", int'(bod_off), 1);
      tick(3); chk("R6 cleared", int'(bods_status), 0);
      chk("R7 held", int'(bod_off), 1);
      pulse_sleep(1'b1, 1'b1); chk("R8 wake wins", int'(bod_off), 0);

      // R5 last edge of the window accepted
      wr(1'b1, 8'h03); tick(3);
      wr(1'b1, 8'h02); tick(3);
      chk("R5 last edge", int'(bods_status), 1);
      tick(4);
      pulse_sleep(1'b1, 1'b0); chk("R7 sleep late", int'(bod_off), 0);

      // R5 first edge after the window ignored
      wr(1'b1, 8'h03); tick(4);
      wr(1'b1, 8'h02); tick(3);
      chk("R5 late ignored", int'(bods_status), 0);
      tick(3);

      // R10 re-arm while pending
      wr(1'b1, 8'h03); wr(1'b1, 8'h02);
      wr(1'b1, 8'h03); wr(1'b1, 8'h02);
      tick(1); chk("R10 timing kept", int'(bods_status), 1);
      tick(3); chk("R10 no restart", int'(bods_status), 0);
      tick(6);

      // mixed traffic against the model
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom % 4;
         bus_addr = 1'($urandom);
         bus_wr = 1'($urandom);
         bus_wdata = (r == 0) ? 8'h03 : (r == 1) ? 8'h02 : 8'($urandom);
         sleep_req = ($urandom % 4) == 0;
         wake_req = ($urandom % 10) == 0;
         adc_enable = ($urandom % 3) == 0;
         tick(1);
      end
      bus_wr = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
      tick(2);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule